// File: doc/BRIEF.md
# Dual-Clock Bypass Mailbox Pair

This block carries single command words between two ports that run on unrelated clocks, without passing them through a data queue. It holds two mailbox registers. The first is loaded from port A and read out on port B. The second is loaded from port B and read out on port A. Each mailbox has an empty/held flag. Once a word is loaded, the flag locks the mailbox against further loads until the opposite port has read it. The flag is exchanged between the clock domains as a toggle through two-flop synchronizers. Each port sees its own synchronized copy of every flag.

On each port, a mailbox-select line chooses what the port's read bus shows: the queue's output register or the incoming mailbox. A shared bus-size setting sets how many low bits are used. Unused input lines are discarded on a load. Unused output lines are driven to zero. When a port is deselected or set to write direction, its output enable is low.

Top module: `dual_clock_mailbox`

## Requirements
- R1: After reset, all four flag outputs are HIGH (mailbox empty), both mailboxes read as zero, and both output enables are LOW.
- R2: A port loads its outgoing mailbox on a rising edge of its clock when select_n=0, write=1, enable=1 and mbox=1, provided its own view of that flag is HIGH. The writer's flag view then reads LOW after that edge, and the reader's flag view reads LOW within three reader clock edges.
- R3: A load attempt while the writer's view of the flag is LOW is ignored, and the mailbox keeps its earlier word. This holds when the attempt falls in the same window as the opposite port's read.
- R4: A read on the opposite port (select_n=0, write=0, enable=1, mbox=1) while the reader's flag view is LOW sets that view HIGH after the edge. The writer's view returns HIGH within three writer clock edges.
- R5: Reading never changes a mailbox's contents. A second read, made after the flag has returned HIGH, shows the same word.
- R6: Bus size code 00 and 11 use bits 35:0, code 01 uses bits 17:0, and code 10 uses bits 8:0. Input bits above the used width are not stored, and output bits above it are driven to 0.
- R7: With select_n=0 and write=0, output enable is HIGH. The port data output then equals the queue output input when mbox=0, and the incoming mailbox word (masked per R6) when mbox=1.
- R8: With select_n=1 or write=1, output enable is LOW and the port data output is all zeros.
- R9: With enable=0, no load and no flag-releasing read takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A domain reset, active low |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B domain reset, active low |
| bus_size | input | 2 | Used-width code (R6) |
| a_sel_n | input | 1 | Port A select, active low |
| a_write | input | 1 | Port A direction, 1 = write |
| a_en | input | 1 | Port A transfer enable |
| a_mbox | input | 1 | Port A mailbox select |
| a_din | input | 36 | Port A write data |
| a_fifo_q | input | 36 | Queue output register shown on port A |
| a_dout | output | 36 | Port A read data |
| a_oe | output | 1 | Port A output enable |
| b_sel_n | input | 1 | Port B select, active low |
| b_write | input | 1 | Port B direction, 1 = write |
| b_en | input | 1 | Port B transfer enable |
| b_mbox | input | 1 | Port B mailbox select |
| b_din | input | 36 | Port B write data |
| b_fifo_q | input | 36 | Queue output register shown on port B |
| b_dout | output | 36 | Port B read data |
| b_oe | output | 1 | Port B output enable |
| mb1_empty_a | output | 1 | Mailbox 1 flag, port A view (1 = empty) |
| mb1_empty_b | output | 1 | Mailbox 1 flag, port B view |
| mb2_empty_a | output | 1 | Mailbox 2 flag, port A view |
| mb2_empty_b | output | 1 | Mailbox 2 flag, port B view |

## Verification
The load and the release of the same mailbox can fall in the same window. The reader frees the slot on its own clock while the writer's view is still LOW, because the acknowledge is still in the synchronizer. The bench provokes this by starting a port B read of mailbox 1 and a port A load of a new word at once. It judges the result by reading the mailbox again after both flags have settled: the original word must still be there, and both views must be HIGH.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [1:0] SZ_FULL   = 2'b00;
  localparam logic [1:0] SZ_MID    = 2'b01;
  localparam logic [1:0] SZ_NARROW = 2'b10;

  // number of low lanes in use for a size code
  function automatic int used_lanes(input logic [1:0] sz, input int full_w,
                                    input int mid_w, input int narrow_w);
    case (sz)
      SZ_MID:    return mid_w;
      SZ_NARROW: return narrow_w;
      default:   return full_w;
    endcase
  endfunction
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_req,
  output logic [DATA_W-1:0] data_q,
  output logic              empty_w,
  output logic              empty_r
);
  logic wr_tog, ack_tog, ack_seen_w, wr_seen_r;
  logic wr_accept, rd_accept;
  logic [DATA_W-1:0] store;

  assign wr_accept = wr_req & empty_w;
  assign rd_accept = rd_req & ~empty_r;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wr_tog <= 1'b0;
      store  <= '0;
    end else if (wr_accept) begin
      wr_tog <= ~wr_tog;
      store  <= wr_data;
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)        ack_tog <= 1'b0;
    else if (rd_accept) ack_tog <= ~ack_tog;
  end

  mbx_sync #(.STAGES(SYNC_STAGES)) u_ack_to_w (
    .clk(wclk), .rst_n(wrst_n), .d(ack_tog), .q(ack_seen_w));
  mbx_sync #(.STAGES(SYNC_STAGES)) u_wr_to_r (
    .clk(rclk), .rst_n(rrst_n), .d(wr_tog), .q(wr_seen_r));

  assign empty_w = (wr_tog == ack_seen_w);
  assign empty_r = (wr_seen_r == ack_tog);
  assign data_q  = store;

  // R2
  load_locks_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    wr_accept |=> !empty_w);
  // R3
  blocked_load_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_req && !empty_w) |=> $stable(data_q));
  // R4
  read_release_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_accept |=> empty_r);
  // R5
  held_word_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!empty_r && $past(!empty_r)) |-> $stable(data_q));
endmodule

// File: rtl/mbx_port.sv
module mbx_port
  import mbx_pkg::*;
#(
  parameter int DATA_W   = 36,
  parameter int MID_W    = 18,
  parameter int NARROW_W = 9
) (
  input  logic [1:0]        bus_size,
  input  logic              sel_n,
  input  logic              write,
  input  logic              en,
  input  logic              mbox,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] fifo_q,
  input  logic [DATA_W-1:0] mail_q,
  output logic              mb_wr_req,
  output logic              mb_rd_req,
  output logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] dout,
  output logic              oe
);
  function automatic logic [DATA_W-1:0] lane_mask(input int w);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < w);
    return m;
  endfunction

  logic [DATA_W-1:0] mask;
  logic              xfer;

  assign mask      = lane_mask(used_lanes(bus_size, DATA_W, MID_W, NARROW_W));
  assign xfer      = ~sel_n & en & mbox;
  assign mb_wr_req = xfer & write;
  assign mb_rd_req = xfer & ~write;
  assign wr_data   = din & mask;
  assign oe        = ~sel_n & ~write;

  always_comb begin
    if (!oe)       dout = '0;
    else if (mbox) dout = mail_q & mask;
    else           dout = fifo_q;
  end
endmodule

// File: rtl/dual_clock_mailbox.sv
module dual_clock_mailbox #(
  parameter int DATA_W      = 36,
  parameter int MID_W       = 18,
  parameter int NARROW_W    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_a,
  input  logic              rst_a_n,
  input  logic              clk_b,
  input  logic              rst_b_n,
  input  logic [1:0]        bus_size,
  input  logic              a_sel_n,
  input  logic              a_write,
  input  logic              a_en,
  input  logic              a_mbox,
  input  logic [DATA_W-1:0] a_din,
  input  logic [DATA_W-1:0] a_fifo_q,
  output logic [DATA_W-1:0] a_dout,
  output logic              a_oe,
  input  logic              b_sel_n,
  input  logic              b_write,
  input  logic              b_en,
  input  logic              b_mbox,
  input  logic [DATA_W-1:0] b_din,
  input  logic [DATA_W-1:0] b_fifo_q,
  output logic [DATA_W-1:0] b_dout,
  output logic              b_oe,
  output logic              mb1_empty_a,
  output logic              mb1_empty_b,
  output logic              mb2_empty_a,
  output logic              mb2_empty_b
);
  logic              a_wr_req, a_rd_req, b_wr_req, b_rd_req;
  logic [DATA_W-1:0] a_wr_data, b_wr_data, mb1_q, mb2_q;

  mbx_port #(.DATA_W(DATA_W), .MID_W(MID_W), .NARROW_W(NARROW_W)) u_port_a (
    .bus_size(bus_size), .sel_n(a_sel_n), .write(a_write), .en(a_en),
    .mbox(a_mbox), .din(a_din), .fifo_q(a_fifo_q), .mail_q(mb2_q),
    .mb_wr_req(a_wr_req), .mb_rd_req(a_rd_req), .wr_data(a_wr_data),
    .dout(a_dout), .oe(a_oe));

  mbx_port #(.DATA_W(DATA_W), .MID_W(MID_W), .NARROW_W(NARROW_W)) u_port_b (
    .bus_size(bus_size), .sel_n(b_sel_n), .write(b_write), .en(b_en),
    .mbox(b_mbox), .din(b_din), .fifo_q(b_fifo_q), .mail_q(mb1_q),
    .mb_wr_req(b_wr_req), .mb_rd_req(b_rd_req), .wr_data(b_wr_data),
    .dout(b_dout), .oe(b_oe));

  // mailbox 1: loaded on A, drained on B
  mbx_slot #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_mb1 (
    .wclk(clk_a), .wrst_n(rst_a_n), .wr_req(a_wr_req), .wr_data(a_wr_data),
    .rclk(clk_b), .rrst_n(rst_b_n), .rd_req(b_rd_req), .data_q(mb1_q),
    .empty_w(mb1_empty_a), .empty_r(mb1_empty_b));

  // mailbox 2: loaded on B, drained on A
  mbx_slot #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_mb2 (
    .wclk(clk_b), .wrst_n(rst_b_n), .wr_req(b_wr_req), .wr_data(b_wr_data),
    .rclk(clk_a), .rrst_n(rst_a_n), .rd_req(a_rd_req), .data_q(mb2_q),
    .empty_w(mb2_empty_b), .empty_r(mb2_empty_a));

  // R8
  port_a_quiet_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (a_sel_n || a_write) |-> (a_dout == '0));
endmodule

// File: tb/dual_clock_mailbox_tb.sv
module dual_clock_mailbox_tb;
  logic clk_a = 0, clk_b = 0, rst_a_n = 0, rst_b_n = 0;
  logic [1:0] bus_size = 2'b00;
  logic a_sel_n = 1, a_write = 0, a_en = 0, a_mbox = 0;
  logic b_sel_n = 1, b_write = 0, b_en = 0, b_mbox = 0;
  logic [35:0] a_din = '0, b_din = '0, a_fifo_q = '0, b_fifo_q = '0;
  logic [35:0] a_dout, b_dout;
  logic a_oe, b_oe, mb1_empty_a, mb1_empty_b, mb2_empty_a, mb2_empty_b;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk_a = ~clk_a;   // 200 MHz
  always #3.5 clk_b = ~clk_b;

  dual_clock_mailbox u_dut (.*);

  // {dir(1: A->B via mb1, 0: B->A via mb2), size, data in, expected}
  localparam logic [74:0] VEC [7] = '{
    {1'b1, 2'b00, 36'h987654321, 36'h987654321},
    {1'b1, 2'b01, 36'hABCDEF123, 36'h00002F123},
    {1'b1, 2'b10, 36'hFFFFFF1A5, 36'h0000001A5},
    {1'b0, 2'b00, 36'h123456789, 36'h123456789},
    {1'b0, 2'b01, 36'hF0F0F0F0F, 36'h000030F0F},
    {1'b0, 2'b10, 36'h0000003FF, 36'h0000001FF},
    {1'b1, 2'b11, 36'hC3C3C3C3C, 36'hC3C3C3C3C}
  };

  task automatic chk(input logic [35:0] act, input logic [35:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic a_drive(input logic s, w, e, m, input logic [35:0] d);
    a_sel_n = s; a_write = w; a_en = e; a_mbox = m; a_din = d;
  endtask
  task automatic b_drive(input logic s, w, e, m, input logic [35:0] d);
    b_sel_n = s; b_write = w; b_en = e; b_mbox = m; b_din = d;
  endtask

  task automatic load_a(input logic [35:0] d);
    @(negedge clk_a); a_drive(0, 1, 1, 1, d);
    @(negedge clk_a); a_drive(1, 0, 0, 0, '0);
  endtask
  task automatic load_b(input logic [35:0] d);
    @(negedge clk_b); b_drive(0, 1, 1, 1, d);
    @(negedge clk_b); b_drive(1, 0, 0, 0, '0);
  endtask
  task automatic read_b(input logic [35:0] exp, input string tag);
    @(negedge clk_b); b_drive(0, 0, 1, 1, '0); #1;
    chk(b_dout, exp, tag); chk(b_oe, 1, tag);
    @(negedge clk_b); b_drive(1, 0, 0, 0, '0);
  endtask
  task automatic read_a(input logic [35:0] exp, input string tag);
    @(negedge clk_a); a_drive(0, 0, 1, 1, '0); #1;
    chk(a_dout, exp, tag); chk(a_oe, 1, tag);
    @(negedge clk_a); a_drive(1, 0, 0, 0, '0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk_b);
    rst_a_n = 1; rst_b_n = 1;
    repeat (2) @(negedge clk_b);
    // R1 reset state
    chk({mb1_empty_a, mb1_empty_b, mb2_empty_a, mb2_empty_b}, 4'hF, "R1 flags");
    chk({a_oe, b_oe}, 0, "R1 oe");
    read_b(36'h0, "R1 mb1 zero");
    read_a(36'h0, "R1 mb2 zero");

    // vector walk: R2, R4, R6, R7
    for (int i = 0; i < 7; i++) begin
      logic dir; logic [35:0] din, exp;
      {dir, bus_size, din, exp} = VEC[i];
      if (dir) begin
        load_a(din);
        chk(mb1_empty_a, 0, "R2 writer view low");
        repeat (4) @(negedge clk_b);
        chk(mb1_empty_b, 0, "R2 reader view low");
        read_b(exp, "R6 R7 mb1 word");
        chk(mb1_empty_b, 1, "R4 reader view high");
        repeat (4) @(negedge clk_a);
        chk(mb1_empty_a, 1, "R4 writer view high");
      end else begin
        load_b(din);
        chk(mb2_empty_b, 0, "R2 writer view low");
        repeat (4) @(negedge clk_a);
        chk(mb2_empty_a, 0, "R2 reader view low");
        read_a(exp, "R6 R7 mb2 word");
        chk(mb2_empty_a, 1, "R4 reader view high");
        repeat (4) @(negedge clk_b);
        chk(mb2_empty_b, 1, "R4 writer view high");
      end
    end
    bus_size = 2'b00;

    // R3 blocked second load, R5 re-read keeps word
    load_a(36'h111111111);
    load_a(36'h222222222);
    repeat (4) @(negedge clk_b);
    read_b(36'h111111111, "R3 blocked load");
    repeat (4) @(negedge clk_a);
    read_b(36'h111111111, "R5 re-read");
    chk(mb1_empty_b, 1, "R5 flag unchanged by empty read");

    // R3 collision: release and load attempt at once
    load_a(36'h333333333);
    repeat (4) @(negedge clk_b);
    fork
      begin @(negedge clk_b); b_drive(0, 0, 1, 1, '0);
            @(negedge clk_b); b_drive(1, 0, 0, 0, '0); end
      begin @(negedge clk_a); a_drive(0, 1, 1, 1, 36'h444444444);
            @(negedge clk_a); a_drive(1, 0, 0, 0, '0); end
    join
    repeat (5) @(negedge clk_a);
    chk({mb1_empty_a, mb1_empty_b}, 2'b11, "R3 collision flags");
    read_b(36'h333333333, "R3 collision word");

    // R9 enable low: no load
    @(negedge clk_a); a_drive(0, 1, 0, 1, 36'h555555555);
    @(negedge clk_a); a_drive(1, 0, 0, 0, '0);
    chk(mb1_empty_a, 1, "R9 no load flag");
    read_b(36'h333333333, "R9 no load word");
    // R9 enable low: no release
    load_b(36'h0000000AB);
    repeat (4) @(negedge clk_a);
    @(negedge clk_a); a_drive(0, 0, 0, 1, '0);
    @(negedge clk_a); a_drive(1, 0, 0, 0, '0);
    chk(mb2_empty_a, 0, "R9 no release");

    // R7 queue path, R8 disabled outputs
    a_fifo_q = 36'h5A5A5A5A5;
    @(negedge clk_a); a_drive(0, 0, 0, 0, '0); #1;
    chk(a_dout, 36'h5A5A5A5A5, "R7 queue path"); chk(a_oe, 1, "R7 oe");
    a_drive(1, 0, 0, 1, '0); #1;
    chk({a_oe, a_dout}, 37'h0, "R8 deselected");
    a_drive(0, 1, 0, 0, '0); #1;
    chk({a_oe, a_dout}, 37'h0, "R8 write direction");
    a_drive(1, 0, 0, 0, '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule